// File: doc/BRIEF.md
# Split-Immediate Integer ALU

This block is the integer arithmetic and logic stage of a 32-bit datapath. Each operation takes a register operand and a second operand. The second operand is either another register value or a 16-bit immediate that is placed in the upper or lower half of the word. How the rest of the word is filled depends on the operation. Logical AND fills the unused half with ones, so an AND immediate masks only the half it covers. Every other operation fills the unused half with zeros.

The result is combinational. Four status flags (carry, overflow, negative, zero) sit in a register and change only when an operation asks for a flag update. The stored carry feeds the add-with-carry and subtract-with-borrow operations, so a wide sum can be built as a chain of 32-bit steps.

A compare is a flag-setting subtract whose result the caller throws away. Sub-operation 111 belongs to a separate shifter. For that code this block only raises a request line towards the shifter.

Top module: `sia_alu`

## Requirements
- R1: `sub_op_i` selects the operation: 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 OR, 110 XOR. `result_o` is the 32-bit result and appears in the same cycle as the inputs.
- R2: With `use_imm_i`=1 and `hi_sel_i`=0, the second operand is `imm_i` in bits 15..0. For add, subtract, OR and XOR, bits 31..16 of that operand are zero.
- R3: With `use_imm_i`=1 and `hi_sel_i`=1, the second operand is `imm_i` in bits 31..16. For every operation except AND, bits 15..0 of that operand are zero.
- R4: For AND with an immediate, the half of the second operand that the immediate does not cover is all ones.
- R5: `flags_o` is {C,V,N,Z}: bit 3 carry, bit 2 overflow, bit 1 negative, bit 0 zero. The flags are written on a rising clock edge when `valid_i`=1, `set_flags_i`=1 and `sub_op_i` is not 111.
- R6: When `valid_i`=0 or `set_flags_i`=0, `flags_o` keeps its value.
- R7: Add with carry adds the stored C flag. Subtract with borrow also subtracts the stored C flag. Both use the stored C whatever the value of their own `set_flags_i`.
- R8: For arithmetic operations, C is the carry out of bit 31 on additions and the borrow on subtractions. V is set on signed two's-complement overflow.
- R9: For AND, OR and XOR, C and V are written as 0. N is written from bit 31 of the result, and Z is set when the result is zero.
- R10: For `sub_op_i`=111, `result_o` is 0, `shift_req_o` equals `valid_i`, and the flags do not change.
- R11: An active `rst_ni` clears all four flags to 0.
- R12: A compare (a flag-setting subtract of two equal values) leaves Z=1 and C=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| sub_op_i | input | 3 | Sub-operation code |
| use_imm_i | input | 1 | 1: second operand is the immediate |
| hi_sel_i | input | 1 | 1: immediate goes in the upper half |
| set_flags_i | input | 1 | 1: write the status flags |
| rs1_i | input | 32 | First register operand |
| rs2_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate |
| result_o | output | 32 | Operation result |
| shift_req_o | output | 1 | Request to the external shifter |
| flags_o | output | 4 | Stored flags {C,V,N,Z} |

## Verification
The hardest case to reach is an add with carry or subtract with borrow whose outcome depends on a carry that an earlier operation left behind. The flags are not visible at the ports until a clock edge has passed. For that reason the vector table is walked in order, with each row setting up the stored carry that the next carry-consuming row relies on. Some of those consuming rows do not update the flags themselves. Signed overflow is reached with operands at the 0x7FFFFFFF and 0x80000000 boundaries.

// File: rtl/sia_pkg.sv
package sia_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_ADC = 3'b001,
    OP_SUB = 3'b010,
    OP_SBB = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_XOR = 3'b110,
    OP_SHF = 3'b111
  } sub_op_e;

  typedef struct packed {
    logic c;
    logic v;
    logic n;
    logic z;
  } flags_t;

  function automatic logic is_logic_op(sub_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction
endpackage

// File: rtl/sia_operand.sv
module sia_operand
  import sia_pkg::*;
#(
  parameter int W = 32,
  localparam int HALF = W / 2
) (
  input  sub_op_e         op_i,
  input  logic            use_imm_i,
  input  logic            hi_sel_i,
  input  logic [W-1:0]    rs2_i,
  input  logic [HALF-1:0] imm_i,
  output logic [W-1:0]    opb_o
);
  logic [HALF-1:0] fill;
  logic [W-1:0]    imm_word;

  // AND keeps the other half untouched by filling it with ones
  assign fill     = (op_i == OP_AND) ? {HALF{1'b1}} : {HALF{1'b0}};
  assign imm_word = hi_sel_i ? {imm_i, fill} : {fill, imm_i};
  assign opb_o    = use_imm_i ? imm_word : rs2_i;
endmodule

// File: rtl/sia_arith.sv
module sia_arith
  import sia_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         chain_i,
  input  logic         c_flag_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] b_eff;
  logic         cin;
  logic         cout;

  assign b_eff = sub_i ? ~b_i : b_i;

  // subtract: cin=1 is plain, a stored borrow removes it
  always_comb begin
    if (sub_i) cin = chain_i ? ~c_flag_i : 1'b1;
    else       cin = chain_i ? c_flag_i : 1'b0;
  end

  assign {cout, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign c_o = sub_i ? ~cout : cout;
  assign v_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/sia_logic.sv
module sia_logic
  import sia_pkg::*;
#(
  parameter int W = 32
) (
  input  sub_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/sia_flags.sv
module sia_flags
  import sia_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t flags_d_i,
  output flags_t flags_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q_o <= '0;
    else if (we_i) flags_q_o <= flags_d_i;
  end

  // R6: no write strobe, no change
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flags_q_o));
endmodule

// File: rtl/sia_alu.sv
module sia_alu
  import sia_pkg::*;
#(
  parameter int W = 32,
  localparam int HALF = W / 2,
  localparam int NFLAGS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        sub_op_i,
  input  logic              use_imm_i,
  input  logic              hi_sel_i,
  input  logic              set_flags_i,
  input  logic [W-1:0]      rs1_i,
  input  logic [W-1:0]      rs2_i,
  input  logic [HALF-1:0]   imm_i,
  output logic [W-1:0]      result_o,
  output logic              shift_req_o,
  output logic [NFLAGS-1:0] flags_o
);
  sub_op_e      op;
  logic [W-1:0] opb, arith_res, logic_res;
  logic         arith_c, arith_v, is_sub, is_chain, is_log, is_shf;
  flags_t       flags_q, flags_d;

  assign op       = sub_op_e'(sub_op_i);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBB);
  assign is_chain = (op == OP_ADC) || (op == OP_SBB);
  assign is_log   = is_logic_op(op);
  assign is_shf   = (op == OP_SHF);

  sia_operand #(.W(W)) u_opnd (
    .op_i(op), .use_imm_i(use_imm_i), .hi_sel_i(hi_sel_i),
    .rs2_i(rs2_i), .imm_i(imm_i), .opb_o(opb)
  );

  sia_arith #(.W(W)) u_arith (
    .a_i(rs1_i), .b_i(opb), .sub_i(is_sub), .chain_i(is_chain),
    .c_flag_i(flags_q.c), .sum_o(arith_res), .c_o(arith_c), .v_o(arith_v)
  );

  sia_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(rs1_i), .b_i(opb), .res_o(logic_res)
  );

  always_comb begin
    if (is_shf)      result_o = '0;
    else if (is_log) result_o = logic_res;
    else             result_o = arith_res;
  end

  assign flags_d.c = is_log ? 1'b0 : arith_c;
  assign flags_d.v = is_log ? 1'b0 : arith_v;
  assign flags_d.n = result_o[W-1];
  assign flags_d.z = (result_o == '0);

  sia_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(valid_i && set_flags_i && !is_shf),
    .flags_d_i(flags_d), .flags_q_o(flags_q)
  );

  assign flags_o     = flags_q;
  assign shift_req_o = valid_i && is_shf;

  // R10: shift code yields zero and leaves flags alone
  a_r10_shift_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_op_i == 3'b111) |-> (result_o == '0));
  a_r10_shift_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sub_op_i == 3'b111) |=> $stable(flags_o));
  // R9: logic ops clear C and V
  a_r9_logic_cv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && set_flags_i && sub_op_i[2] && sub_op_i != 3'b111)
      |=> (flags_o[3:2] == 2'b00));
  // R5: zero result recorded in Z
  a_r5_zero_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && set_flags_i && sub_op_i != 3'b111 && result_o == '0)
      |=> flags_o[0]);
  // R4: AND immediate keeps the uncovered half of rs1
  a_r4_and_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_op_i == 3'b100 && use_imm_i && !hi_sel_i)
      |-> (result_o[W-1:HALF] == rs1_i[W-1:HALF]));
endmodule

// File: tb/sim_sia_alu.sv
module sim_sia_alu;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic        imm;
    logic        hi;
    logic        setf;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] k;
    logic [31:0] res;
    logic [3:0]  fl;
  } vec_t;

  localparam int NV = 15;
  // flags {C,V,N,Z}; rows run in order, carry chains from row to row
  localparam vec_t VECS [NV] = '{
    '{3'b000,1'b0,1'b0,1'b1,32'hFFFFFFFF,32'h1,16'h0,32'h0,4'h9},              // R1 R8 carry out
    '{3'b001,1'b0,1'b0,1'b0,32'h5,32'h7,16'h0,32'hD,4'h9},                     // R7 adc, no flag write
    '{3'b001,1'b1,1'b0,1'b1,32'h7FFFFFFF,32'h0,16'h0000,32'h80000000,4'h6},    // R7 R8 overflow
    '{3'b010,1'b1,1'b1,1'b1,32'h00010000,32'h0,16'h0002,32'hFFFF0000,4'hA},    // R3 R8 borrow
    '{3'b011,1'b0,1'b0,1'b1,32'd10,32'd3,16'h0,32'd6,4'h0},                    // R7 sbb with borrow
    '{3'b011,1'b0,1'b0,1'b1,32'h0,32'h0,16'h0,32'h0,4'h1},                     // R7 sbb no borrow
    '{3'b100,1'b1,1'b0,1'b1,32'hABCD1234,32'h0,16'h00FF,32'hABCD0034,4'h2},    // R4 low AND
    '{3'b100,1'b1,1'b1,1'b0,32'hABCD1234,32'h0,16'h0F0F,32'h0B0D1234,4'h2},    // R4 high AND
    '{3'b110,1'b0,1'b0,1'b1,32'h5A5A5A5A,32'h5A5A5A5A,16'h0,32'h0,4'h1},       // R9 xor to zero
    '{3'b101,1'b1,1'b1,1'b1,32'h00001234,32'h0,16'h8000,32'h80001234,4'h2},    // R3 R9 or high
    '{3'b110,1'b1,1'b0,1'b1,32'hFFFF0000,32'h0,16'hFFFF,32'hFFFFFFFF,4'h2},    // R2 xor low
    '{3'b010,1'b0,1'b0,1'b1,32'h80000000,32'h1,16'h0,32'h7FFFFFFF,4'h4},       // R8 sub overflow
    '{3'b000,1'b1,1'b1,1'b1,32'h0000FFFF,32'h0,16'h8000,32'h8000FFFF,4'h2},    // R3 add high
    '{3'b111,1'b0,1'b0,1'b1,32'h12345678,32'h3,16'h0,32'h0,4'h2},              // R10 shift code
    '{3'b000,1'b1,1'b0,1'b1,32'h10000000,32'h0,16'hFFFF,32'h1000FFFF,4'h0}     // R2 add low
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [2:0]  sub_op_i = '0;
  logic        use_imm_i = 1'b0, hi_sel_i = 1'b0, set_flags_i = 1'b0;
  logic [31:0] rs1_i = '0, rs2_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] result_o;
  logic        shift_req_o;
  logic [3:0]  flags_o;
  int          n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sia_alu u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] op, logic imm, logic hi, logic setf,
                       logic [31:0] a, logic [31:0] b, logic [15:0] k, logic v);
    sub_op_i = op; use_imm_i = imm; hi_sel_i = hi; set_flags_i = setf;
    rs1_i = a; rs2_i = b; imm_i = k; valid_i = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R11 flags in reset", {28'h0, flags_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 flags after reset", {28'h0, flags_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].imm, VECS[i].hi, VECS[i].setf,
            VECS[i].a, VECS[i].b, VECS[i].k, 1'b1);
      #1;
      check($sformatf("R1 vec %0d result", i), result_o, VECS[i].res);
      check($sformatf("R10 vec %0d shift_req", i), {31'h0, shift_req_o},
            {31'h0, VECS[i].op == 3'b111});
      @(negedge clk_i);
      valid_i = 1'b0;
      check($sformatf("R5 vec %0d flags", i), {28'h0, flags_o}, {28'h0, VECS[i].fl});
    end

    // R12 compare: equal operands, result discarded
    drive(3'b010, 1'b0, 1'b0, 1'b1, 32'h55, 32'h55, 16'h0, 1'b1);
    @(negedge clk_i);
    check("R12 compare flags", {28'h0, flags_o}, 32'h1);

    // R6 valid low ignores a flag-setting op
    drive(3'b000, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b0);
    @(negedge clk_i);
    check("R6 valid low keeps flags", {28'h0, flags_o}, 32'h1);

    // R11 reset clears flags mid-run
    drive(3'b000, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b1);
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R8 carry set before reset", {28'h0, flags_o}, 32'h9);
    rst_ni = 1'b0;
    #1;
    check("R11 async reset clears", {28'h0, flags_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7 adc after reset sees C=0
    drive(3'b001, 1'b0, 1'b0, 1'b0, 32'h5, 32'h7, 16'h0, 1'b1);
    #1;
    check("R7 adc with clear carry", result_o, 32'hC);
    @(negedge clk_i);
    valid_i = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule